// File: doc/BRIEF.md
# Pipelined Burst Static RAM Core

This core holds the storage and control of a synchronous, pipelined burst static RAM. Each word is made of four byte lanes, and each lane is nine bits wide: eight data bits with a parity bit on top. Two active-low strobes start an access. The CPU strobe wins over the controller strobe. The core captures the presented address only when its three chip selects agree. The two low address bits seed a burst counter. An active-low advance input then steps that counter through the burst.

Writes cover either the whole word or chosen lanes. Read data leaves through one output register. A drive flag tells the pad logic when the data pins should be driven. A sleep input freezes all activity and keeps the stored words intact.

Top module: `burst_sram_core`

## Requirements
- R1: On a rising edge where an address strobe is accepted, the selects qualify it when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. When they qualify, the core registers the whole address and the device becomes selected.
- R2: A low `cpu_strobe_n` is ignored while `sel_a_n` is high. A low `ctl_strobe_n` is acted on whatever `sel_a_n` is.
- R3: When both strobes are low and `sel_a_n` is low, only the CPU strobe is acted on. In that cycle nothing is written, even if the controller strobe and the write inputs ask for a write.
- R4: The selects are looked at only on an accepted strobe. A strobe with selects that do not qualify deselects the device. Without a strobe, the select state is kept whatever the select pins do.
- R5: The burst counter holds address bits [1:0]. It steps +1 modulo 4 (for example 2,3,0,1) on each edge where `advance_n`=0 and no strobe is accepted. The upper address bits do not change during a burst.
- R6: `wr_all_n`=0 in a write-eligible cycle writes all four lanes, whatever `wr_lane_en_n` and `lane_sel_n` are.
- R7: When `wr_all_n`=1, lane i (`wdata[9i+8:9i]`, with parity in bit 9i+8) is written only when `wr_lane_en_n`=0 and `lane_sel_n[i]`=0.
- R8: A cycle that accepts the CPU strobe writes nothing. A write is taken either in a cycle that accepts the controller strobe (at the newly presented address) or in a following cycle with no strobe (at the current burst address, before any advance).
- R9: A read of the address held after edge k shows on `rdata` after edge k+1. Each selected cycle without a write performs a read.
- R10: `rdata_drive` is high only when `out_en_n`=0 and the output register holds a read result. It is low after reset. It is also low during the first cycle after a load that brings the device out of the deselected state.
- R11: While `sleep`=1, strobes, advance and writes are ignored, `rdata_drive` is low, and the stored contents are kept. Normal operation resumes on the first edge after `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cpu_strobe_n | input | 1 | CPU address strobe, active low, priority strobe |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low, also gates the CPU strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_lane_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Registered read data |
| rdata_drive | output | 1 | High when the data pins should drive `rdata` |

## Verification
The test sequences cover:
- whole-word writes against partial-lane writes, including a lane select with the lane enable off, which must leave the word untouched;
- CPU-strobe cycles against controller-strobe cycles, alone and together, to show the priority and the held-off write;
- a burst started at address offset 2, so the counter must wrap from 3 to 0 while the upper bits stay put;
- selects that fail to qualify, and select changes on cycles with no strobe;
- output enable held high, the first cycle out of deselect, and a sleep window that carries strobes and writes.

Each of these cases checks the drive flag and the data seen after the pipeline register.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst SRAM core.
package burst_sram_pkg;
    // Kind of address load accepted on an edge.
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_CPU  = 2'd1,
        LD_CTL  = 2'd2
    } load_e;
endpackage

// File: rtl/burst_sram_addr_ctrl.sv
`timescale 1ns/1ps
// Address and select control: arbitrates the two strobes, captures the
// address and the select state, and runs the two-bit burst counter.
// Assumes ADDR_W >= 3 and that sleep blocks every state change.
module burst_sram_addr_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              advance_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              sleep,
    output load_e             load_kind,
    output logic              sel_q,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int UPPER_W = ADDR_W - 2;

    logic [UPPER_W-1:0] upper_q;
    logic [1:0]         burst_q;
    logic               qual;

    // Strobe arbitration: CPU strobe needs select A, and wins over the controller strobe.
    always_comb begin
        qual = ~sel_a_n & sel_b & ~sel_c_n;
        if (sleep)
            load_kind = LD_NONE;
        else if (~cpu_strobe_n & ~sel_a_n)
            load_kind = LD_CPU;
        else if (~ctl_strobe_n)
            load_kind = LD_CTL;
        else
            load_kind = LD_NONE;
    end

    // Select state and address register, burst counter steps when no load happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            upper_q <= '0;
            burst_q <= 2'd0;
        end else if (load_kind != LD_NONE) begin
            sel_q <= qual;
            if (qual) begin
                upper_q <= addr[ADDR_W-1:2];
                burst_q <= addr[1:0];
            end
        end else if (!sleep && !advance_n) begin
            burst_q <= burst_q + 2'd1;
        end
    end

    // Write target: a controller load writes the new address, otherwise the current one.
    always_comb begin
        cur_addr = {upper_q, burst_q};
        wr_addr  = (load_kind == LD_CTL) ? addr : cur_addr;
        wr_sel   = (load_kind == LD_CTL) ? qual : sel_q;
    end
endmodule

// File: rtl/burst_sram_lane_decode.sv
`timescale 1ns/1ps
// Write-lane decode: turns whole-word and per-lane write controls into one
// write enable per byte lane. Assumes write_ok already folds in select,
// sleep and strobe rules.
module burst_sram_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             write_ok,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane enable: whole-word write overrides the lane selects.
        always_comb lane_we[i] = write_ok & (~wr_all_n | (~wr_lane_en_n & ~lane_sel_n[i]));
    end
endmodule

// File: rtl/burst_sram_array.sv
`timescale 1ns/1ps
// Storage array split into byte lanes, with one registered read port.
// Reads see the contents before a write on the same edge. The array has no reset.
module burst_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane write port.
        always_ff @(posedge clk) begin
            if (lane_we[i])
                mem[wr_addr] <= wdata[i*LANE_W +: LANE_W];
        end

        // Lane read register, the single pipeline stage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q <= '0;
            else
                rd_q <= mem[rd_addr];
        end

        assign rdata[i*LANE_W +: LANE_W] = rd_q;
    end

    // Marks that the output register holds a real read result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= rd_en;
    end
endmodule

// File: rtl/burst_sram_core.sv
`timescale 1ns/1ps
// Top of the burst SRAM core: address control, lane decode and array.
// The data pins are modelled as rdata plus a drive flag for the pad ring.
module burst_sram_core
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    advance_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    load_e             load_kind;
    logic              sel_q;
    logic              wr_sel;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic              write_ok;
    logic [LANES-1:0]  lane_we;
    logic              rd_en;
    logic              rd_valid;

    burst_sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .advance_n    (advance_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .sleep        (sleep),
        .load_kind    (load_kind),
        .sel_q        (sel_q),
        .wr_sel       (wr_sel),
        .cur_addr     (cur_addr),
        .wr_addr      (wr_addr)
    );

    // Writes need a selected target, no sleep and no CPU-strobe load.
    always_comb write_ok = ~sleep & (load_kind != LD_CPU) & wr_sel;

    burst_sram_lane_decode #(.LANES(LANES)) u_dec (
        .write_ok     (write_ok),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .lane_sel_n   (lane_sel_n),
        .lane_we      (lane_we)
    );

    // A selected cycle that is not writing reads the current address.
    always_comb rd_en = sel_q & ~(|lane_we) & ~sleep;

    burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_we  (lane_we),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rd_addr  (cur_addr),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    // Pin drive: output enable qualified by a held read result and no sleep.
    always_comb rdata_drive = rd_valid & ~out_en_n & ~sleep;
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
// Protocol checker for burst_sram_core, attached by bind.
module burst_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              advance_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              wr_all_n,
    input logic              wr_lane_en_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              out_en_n,
    input logic              sleep,
    input logic              sel_q,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [LANES-1:0]  lane_we,
    input logic              rdata_drive
);
    logic acc, no_load;
    always_comb begin
        acc     = ~sleep & ((~cpu_strobe_n & ~sel_a_n) | ~ctl_strobe_n);
        no_load = sleep | ((cpu_strobe_n | sel_a_n) & ctl_strobe_n);
    end

    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !sel_a_n && sel_b && !sel_c_n) |=> (cur_addr == $past(addr)) && sel_q);

    a_r2_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cpu_strobe_n && sel_a_n && ctl_strobe_n && advance_n)
        |=> $stable(cur_addr) && $stable(sel_q));

    a_r3_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !sel_a_n && !ctl_strobe_n) |-> (lane_we == '0));

    a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        no_load |=> $stable(sel_q));

    a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && !sleep && !advance_n)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)
            && (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    a_r6_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_we) && !wr_all_n) |-> (&lane_we));

    a_r7_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all_n |-> ((lane_we & lane_sel_n) == '0) && (wr_lane_en_n ? (lane_we == '0) : 1'b1));

    a_r8_cpu_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !sel_a_n) |-> (lane_we == '0));

    a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drive |-> !out_en_n);

    a_r10_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |=> !rdata_drive);

    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_drive && (lane_we == '0));

    a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(cur_addr) && $stable(sel_q));
endmodule

bind burst_sram_core burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .advance_n    (advance_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .out_en_n     (out_en_n),
    .sleep        (sleep),
    .sel_q        (sel_q),
    .cur_addr     (cur_addr),
    .lane_we      (lane_we),
    .rdata_drive  (rdata_drive)
);

// File: tb/burst_sram_core_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task predicts each cycle's output from a
// requirement-level model and queues it; the monitor compares after each edge.
module burst_sram_core_tb;
    localparam int AW = 8;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, advance_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          out_en_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int tests = 0, fails = 0, cyc = 0;

    typedef struct {
        int            due;
        bit            drv;
        bit            dchk;
        logic [DW-1:0] data;
        string         tag;
    } item_t;
    item_t sb[$];

    logic [DW-1:0] mem_m [256];
    bit            mv [256];
    bit            m_sel = 1'b0;
    logic [AW-1:0] m_addr = '0;

    burst_sram_core u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .advance_n(advance_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .sleep(sleep), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    always #2 clk = ~clk;

    // Monitor: compares the queued prediction against the outputs just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                it = sb.pop_front();
                tests++;
                if (rdata_drive !== it.drv) begin
                    fails++;
                    $display("FAIL %s cyc %0d: drive=%b expected %b", it.tag, cyc, rdata_drive, it.drv);
                end else if (it.drv && it.dchk && rdata !== it.data) begin
                    fails++;
                    $display("FAIL %s cyc %0d: rdata=%h expected %h", it.tag, cyc, rdata, it.data);
                end
            end
        end
    end

    // Driver step: inputs are set, predict this edge, advance the model, go to next negedge.
    task automatic step(input string tag);
        item_t it;
        bit load_p, load_c, qual, wreq, wr;
        logic [AW-1:0] wa;
        load_p = !sleep && !cpu_strobe_n && !sel_a_n;
        load_c = !sleep && !ctl_strobe_n && !load_p;
        qual   = !sel_a_n && sel_b && !sel_c_n;
        wreq   = !wr_all_n || (!wr_lane_en_n && lane_sel_n != 4'hF);
        wr     = !sleep && !load_p && wreq && (load_c ? qual : m_sel);
        wa     = load_c ? addr : m_addr;
        it.due  = cyc + 1;
        it.drv  = m_sel && !wr && !sleep && !out_en_n;
        it.dchk = mv[m_addr];
        it.data = mem_m[m_addr];
        it.tag  = tag;
        sb.push_back(it);
        if (wr) begin
            for (int i = 0; i < 4; i++)
                if (!wr_all_n || !lane_sel_n[i])
                    mem_m[wa][i*9 +: 9] = wdata[i*9 +: 9];
            if (!mv[wa] && !(!wr_all_n || lane_sel_n == 4'h0))
                mem_m[wa] = mem_m[wa];
            mv[wa] = mv[wa] || !wr_all_n || (lane_sel_n == 4'h0);
        end
        if (load_p || load_c) begin
            m_sel = qual;
            if (qual) m_addr = addr;
        end else if (!sleep && !advance_n) begin
            m_addr[1:0] = m_addr[1:0] + 2'd1;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; advance_n = 1'b1;
        wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_sel_n = 4'hF;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        quiet(); addr = a; ctl_strobe_n = 1'b0; wr_all_n = 1'b0; wdata = d;
        step(tag);
    endtask

    task automatic ctl_read(input logic [AW-1:0] a, input string tag);
        quiet(); addr = a; ctl_strobe_n = 1'b0;
        step(tag);
        quiet(); step(tag);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #800000;
        fails++; tests++;
        $display("FAIL watchdog: expired, expected end of sequence");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tests++;
        if (rdata_drive !== 1'b0) begin
            fails++; $display("FAIL R10 reset: drive=%b expected 0", rdata_drive);
        end

        // R1 R6 R9: whole-word writes then reads with one-stage latency
        ctl_write(8'h10, 36'h1_2345_6789, "R6 whole write");
        ctl_write(8'h11, 36'hF_EDCB_A987, "R6 whole write");
        ctl_read(8'h10, "R1 R9 read");
        ctl_read(8'h11, "R9 read");

        // R7: partial lanes, and lane selects without lane enable
        ctl_write(8'h20, 36'h0_0000_0000, "R6 clear");
        quiet(); addr = 8'h20; ctl_strobe_n = 1'b0; wr_lane_en_n = 1'b0;
        lane_sel_n = 4'b1010; wdata = 36'hA_BCDE_F012; step("R7 lanes 0 2");
        quiet(); addr = 8'h20; ctl_strobe_n = 1'b0; wr_lane_en_n = 1'b1;
        lane_sel_n = 4'b0000; wdata = 36'hF_FFFF_FFFF; step("R7 no enable");
        ctl_read(8'h20, "R7 readback");

        // R8: CPU-strobe cycle does not write; following cycle does
        ctl_write(8'h30, 36'h5_5555_5555, "R8 seed");
        quiet(); addr = 8'h30; cpu_strobe_n = 1'b0; wr_all_n = 1'b0; wdata = 36'h0_DEAD_BEEF;
        step("R8 cpu cycle");
        quiet(); step("R8 no write follow");
        quiet(); step("R8 readback");
        quiet(); wr_all_n = 1'b0; wdata = 36'h3_3333_3333; step("R8 later write");
        quiet(); step("R8 read"); quiet(); step("R8 read");

        // R3: both strobes, controller asks to write, CPU wins
        quiet(); addr = 8'h11; cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0;
        wr_all_n = 1'b0; wdata = 36'h0; step("R3 both strobes");
        quiet(); step("R3 read"); quiet(); step("R3 read");

        // R2: CPU strobe with select A high is ignored
        quiet(); addr = 8'h20; cpu_strobe_n = 1'b0; sel_a_n = 1'b1; step("R2 ignored");
        quiet(); step("R2 same addr"); quiet(); step("R2 same addr");

        // R4: disqualified load deselects; non-load cycles keep it
        quiet(); addr = 8'h10; ctl_strobe_n = 1'b0; sel_b = 1'b0; step("R4 deselect");
        quiet(); step("R4 held"); quiet(); step("R4 held");
        // R10: first cycle out of deselect is masked
        ctl_read(8'h10, "R10 first masked");
        quiet(); step("R10 drive");

        // R5: burst from offset 2, wraps modulo 4
        ctl_write(8'h40, 36'h0_0000_0040, "R5 fill");
        ctl_write(8'h41, 36'h0_0000_0041, "R5 fill");
        ctl_write(8'h42, 36'h0_0000_0042, "R5 fill");
        ctl_write(8'h43, 36'h0_0000_0043, "R5 fill");
        quiet(); addr = 8'h42; ctl_strobe_n = 1'b0; step("R5 load");
        for (int k = 0; k < 5; k++) begin
            quiet(); advance_n = 1'b0; step("R5 burst");
        end
        quiet(); step("R5 end");

        // R10: output enable high stops the drive
        quiet(); out_en_n = 1'b1; step("R10 oe high"); step("R10 oe high");
        out_en_n = 1'b0; step("R10 oe low");

        // R11: sleep ignores strobes and writes, keeps contents
        quiet(); sleep = 1'b1; addr = 8'h10; ctl_strobe_n = 1'b0; wr_all_n = 1'b0;
        wdata = 36'h0; step("R11 sleep");
        advance_n = 1'b0; step("R11 sleep");
        quiet(); sleep = 1'b0; step("R11 wake");
        ctl_read(8'h10, "R11 contents");
        quiet(); step("R11 read");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule